// File: doc/BRIEF.md
# Framed Stream Stage with Swappable Context

This block wraps a 16-bit streaming processing stage of the kind used for filtering or hit-finding. Input words arrive framed into packets: a qualifier marks each live word and a marker flags the final word of a packet. The opening word of each packet is a header. It does not enter the processing path and appears at the output unchanged. The words after it pass through a placeholder running-sum filter. The output keeps the input framing with a fixed delay of one cycle.

The filter keeps all of its state in one 16-bit context word, so a single instance can be time-shared between channels. Outside logic can write a saved context in through a dedicated configuration input and take a snapshot of the live context out through a configuration output. A context can also be delivered inside the data stream. A header whose top bit is set opens a configuration packet. Each payload word of that packet is written into the context, and nothing of the packet reaches the output.

Top module: `stream_ctx_wrap`

## Requirements
- R1: During and after reset, out_valid and out_last are 0, the context reads 0, and the next live word is treated as a header.
- R2: A header word with bit 15 clear appears on out_data unchanged, with out_valid high, one cycle after it is accepted.
- R3: Each payload word x of a data packet updates the context to ctx + x and presents that new value on out_data one cycle later.
- R4: out_valid and out_last reproduce in_valid and in_last with a one-cycle delay for every forwarded word. A cycle with in_valid low produces no output and changes neither the framing nor the context.
- R5: A header with bit 15 set starts a configuration packet. Its payload words are written into the context in arrival order, so the last one remains. No word of that packet, the header included, raises out_valid.
- R6: A cycle with ctx_load high writes ctx_wr_data into the context. This takes priority over an in-band write or a running-sum update in the same cycle.
- R7: A cycle with ctx_store high makes ctx_rd_data show, from the next cycle on, the context as it was before that edge. ctx_rd_data holds its value until the next store.
- R8: The context carries over from one packet to the next. A header that also carries in_last forms a complete packet, and the word after it is again a header.
- R9: The running sum wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_data | input | 16 | Stream input word |
| in_valid | input | 1 | Input word is live |
| in_last | input | 1 | Input word ends its packet |
| out_data | output | 16 | Stream output word |
| out_valid | output | 1 | Output word is live |
| out_last | output | 1 | Output word ends its packet |
| ctx_wr_data | input | 16 | Context value to write in |
| ctx_rd_data | output | 16 | Context snapshot taken on store |
| ctx_load | input | 1 | Write ctx_wr_data into the context |
| ctx_store | input | 1 | Capture the context on ctx_rd_data |

## Verification
A framing state that has slipped by one word shows up within one cycle. A header either comes out as a sum, or a payload word is passed through raw, and when a header bit 15 is misread a packet is dropped or leaked whole. A wrong context value only shows when a later payload word is summed or a store is issued, so the checks take a snapshot of the context after every scenario. Priority and ordering faults are caught by having load and in-band writes collide in the same cycle, and by multi-word configuration packets whose last word must win.

// File: rtl/stream_ctx_pkg.sv
package stream_ctx_pkg;
  parameter int DW = 16;
  localparam int FLAG_BIT = DW - 1;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_DATA = 2'd1,
    ST_CFG  = 2'd2
  } frame_st_e;
endpackage

// File: rtl/frame_tracker.sv
module frame_tracker
  import stream_ctx_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic in_valid,
  input  logic in_last,
  input  logic hdr_flag,
  output logic at_hdr,
  output logic in_pay,
  output logic in_cfg
);
  frame_st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (in_valid) begin
      if (in_last)              st_d = ST_HDR;
      else if (st_q == ST_HDR)  st_d = hdr_flag ? ST_CFG : ST_DATA;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_HDR;
    else        st_q <= st_d;
  end

  assign at_hdr = (st_q == ST_HDR);
  assign in_pay = (st_q == ST_DATA);
  assign in_cfg = (st_q == ST_CFG);

  // R8: a header carrying last completes its packet
  a_r8_single_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && at_hdr && in_last) |=> at_hdr);
  // R4: idle cycles leave the framing untouched
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid) |=> $stable(st_q));
endmodule

// File: rtl/ctx_keeper.sv
module ctx_keeper
  import stream_ctx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_en,
  input  logic [DW-1:0] ld_data,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          acc_en,
  input  logic [DW-1:0] acc_add,
  input  logic          snap_en,
  output logic [DW-1:0] sum_o,
  output logic [DW-1:0] snap_q
);
  logic [DW-1:0] ctx_q, ctx_d, snap_d;
  logic          ctx_en;

  assign sum_o  = ctx_q + acc_add;
  assign ctx_en = ld_en | wr_en | acc_en;

  always_comb begin
    ctx_d = ctx_q;
    if (ld_en)       ctx_d = ld_data;
    else if (wr_en)  ctx_d = wr_data;
    else if (acc_en) ctx_d = sum_o;
  end

  assign snap_d = snap_en ? ctx_q : snap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ctx_q <= '0;
    else if (ctx_en) ctx_q <= ctx_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  // R6: load wins over any other update
  a_r6_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ld_en |=> (ctx_q == $past(ld_data)));
  // R7: snapshot reflects the pre-edge context
  a_r7_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    snap_en |=> (snap_q == $past(ctx_q)));
  // R7: snapshot holds without store
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !snap_en |=> $stable(snap_q));
  // R5: in-band write lands when not overridden
  a_r5_inband: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !ld_en) |=> (ctx_q == $past(wr_data)));
endmodule

// File: rtl/out_stage.sv
module out_stage
  import stream_ctx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fwd,
  input  logic          last_i,
  input  logic [DW-1:0] word_i,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_last
);
  logic [DW-1:0] data_d;
  logic          valid_d, last_d;

  assign valid_d = fwd;
  assign last_d  = fwd & last_i;
  assign data_d  = fwd ? word_i : out_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_last  <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= valid_d;
      out_last  <= last_d;
      out_data  <= data_d;
    end
  end

  // R4: output strobe and last marker follow the input by one cycle
  a_r4_latency: assert property (@(posedge clk) disable iff (!rst_n)
    fwd |=> (out_valid && (out_last == $past(last_i))));
  a_r4_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !fwd |=> !out_valid);
endmodule

// File: rtl/stream_ctx_wrap.sv
module stream_ctx_wrap
  import stream_ctx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] in_data,
  input  logic          in_valid,
  input  logic          in_last,
  output logic [DW-1:0] out_data,
  output logic          out_valid,
  output logic          out_last,
  input  logic [DW-1:0] ctx_wr_data,
  output logic [DW-1:0] ctx_rd_data,
  input  logic          ctx_load,
  input  logic          ctx_store
);
  logic          at_hdr, in_pay, in_cfg;
  logic          cfg_hdr, drop, fwd, acc_en, wr_en;
  logic [DW-1:0] sum, fwd_word;

  frame_tracker u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_last  (in_last),
    .hdr_flag (in_data[FLAG_BIT]),
    .at_hdr   (at_hdr),
    .in_pay   (in_pay),
    .in_cfg   (in_cfg)
  );

  assign cfg_hdr  = at_hdr & in_data[FLAG_BIT];
  assign drop     = cfg_hdr | in_cfg;
  assign fwd      = in_valid & ~drop;
  assign acc_en   = in_valid & in_pay;
  assign wr_en    = in_valid & in_cfg;
  assign fwd_word = at_hdr ? in_data : sum;

  ctx_keeper u_ctx (
    .clk     (clk),
    .rst_n   (rst_n),
    .ld_en   (ctx_load),
    .ld_data (ctx_wr_data),
    .wr_en   (wr_en),
    .wr_data (in_data),
    .acc_en  (acc_en),
    .acc_add (in_data),
    .snap_en (ctx_store),
    .sum_o   (sum),
    .snap_q  (ctx_rd_data)
  );

  out_stage u_out (
    .clk       (clk),
    .rst_n     (rst_n),
    .fwd       (fwd),
    .last_i    (in_last),
    .word_i    (fwd_word),
    .out_data  (out_data),
    .out_valid (out_valid),
    .out_last  (out_last)
  );

  // R2: plain header passes through unchanged
  a_r2_hdr_bypass: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && at_hdr && !in_data[FLAG_BIT]) |=> (out_data == $past(in_data)));
  // R5: configuration packet words never reach the output
  a_r5_cfg_hidden: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (cfg_hdr || in_cfg)) |=> !out_valid);
  // R1: outputs quiet while in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |-> (!out_valid && !out_last));
endmodule

// File: tb/stream_ctx_wrap_tb.sv
module stream_ctx_wrap_tb;
  logic        clk;
  logic        rst_n;
  logic [15:0] in_data;
  logic        in_valid, in_last;
  logic [15:0] out_data;
  logic        out_valid, out_last;
  logic [15:0] ctx_wr_data, ctx_rd_data;
  logic        ctx_load, ctx_store;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  stream_ctx_wrap u_dut (
    .clk(clk), .rst_n(rst_n),
    .in_data(in_data), .in_valid(in_valid), .in_last(in_last),
    .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
    .ctx_wr_data(ctx_wr_data), .ctx_rd_data(ctx_rd_data),
    .ctx_load(ctx_load), .ctx_store(ctx_store)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one input cycle; returns after the edge, outputs settled
  task automatic step(logic v, logic l, logic [15:0] d);
    @(negedge clk);
    in_valid = v; in_last = l; in_data = d;
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0;
  endtask

  // word that must be forwarded with value exp
  task automatic word_out(string req, logic l, logic [15:0] d, logic [15:0] exp);
    step(1'b1, l, d);
    chk({req, " valid"}, out_valid, 1'b1);
    chk({req, " last"},  out_last,  l);
    chk({req, " data"},  out_data,  exp);
  endtask

  task automatic word_hidden(string req, logic l, logic [15:0] d);
    step(1'b1, l, d);
    chk({req, " hidden"}, out_valid, 1'b0);
  endtask

  task automatic read_ctx(string req, logic [15:0] exp);
    @(negedge clk);
    ctx_store = 1'b1;
    @(posedge clk); #1;
    ctx_store = 1'b0;
    chk({req, " ctx"}, ctx_rd_data, exp);
  endtask

  task automatic load_ctx(logic [15:0] v);
    @(negedge clk);
    ctx_load = 1'b1; ctx_wr_data = v;
    @(posedge clk); #1;
    ctx_load = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 valid", out_valid, 1'b0);
    chk("R1 last",  out_last,  1'b0);
    read_ctx("R1", 16'h0000);
  endtask

  task automatic t_data_packet;
    // R2 header, R3 running sum
    word_out("R2 hdr", 1'b0, 16'h1234, 16'h1234);
    word_out("R3 p0",  1'b0, 16'h0005, 16'h0005);
    step(1'b0, 1'b0, 16'hFFFF);               // R4 idle gap
    chk("R4 idle", out_valid, 1'b0);
    word_out("R3 p1",  1'b0, 16'h0010, 16'h0015);
    word_out("R3 p2",  1'b1, 16'h0001, 16'h0016);
    read_ctx("R3", 16'h0016);
  endtask

  task automatic t_carry;
    // R8 context carries, single-word packet
    word_out("R8 solo", 1'b1, 16'h0042, 16'h0042);
    word_out("R8 hdr",  1'b0, 16'h0043, 16'h0043);
    word_out("R8 p0",   1'b1, 16'h0004, 16'h001A);
    read_ctx("R8", 16'h001A);
  endtask

  task automatic t_cfg_packet;
    // R5 in-band context, last word wins
    word_hidden("R5 hdr", 1'b0, 16'h8001);
    word_hidden("R5 w0",  1'b0, 16'h1111);
    word_hidden("R5 w1",  1'b1, 16'hFFF0);
    read_ctx("R5", 16'hFFF0);
    // R9 wrap of sum from in-band context
    word_out("R9 hdr", 1'b0, 16'h0007, 16'h0007);
    word_out("R9 p0",  1'b1, 16'h0020, 16'h0010);
    read_ctx("R9", 16'h0010);
    // header-only config packet, then plain header
    word_hidden("R5 cfg solo", 1'b1, 16'hC000);
    word_out("R8 after solo", 1'b1, 16'h0100, 16'h0100);
    read_ctx("R5 solo", 16'h0010);
  endtask

  task automatic t_load;
    load_ctx(16'h0200);
    read_ctx("R6", 16'h0200);
    word_out("R6 hdr", 1'b0, 16'h0001, 16'h0001);
    word_out("R6 p0",  1'b1, 16'h0003, 16'h0203);
    // R6 load collides with in-band write
    word_hidden("R6 chdr", 1'b0, 16'h8000);
    @(negedge clk);
    in_valid = 1'b1; in_last = 1'b1; in_data = 16'h5555;
    ctx_load = 1'b1; ctx_wr_data = 16'hABCD;
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; ctx_load = 1'b0;
    chk("R6 clash hidden", out_valid, 1'b0);
    read_ctx("R6 clash", 16'hABCD);
  endtask

  task automatic t_store_hold;
    // R7 snapshot is pre-edge value and holds
    word_out("R7 hdr", 1'b0, 16'h0002, 16'h0002);
    @(negedge clk);
    in_valid = 1'b1; in_last = 1'b1; in_data = 16'h0001; ctx_store = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; in_last = 1'b0; ctx_store = 1'b0;
    chk("R7 pre-edge", ctx_rd_data, 16'hABCD);
    chk("R3 sum", out_data, 16'hABCE);
    step(1'b0, 1'b0, 16'h0000);
    chk("R7 hold", ctx_rd_data, 16'hABCD);
    read_ctx("R7 new", 16'hABCE);
  endtask

  initial begin
    #200000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
    ctx_wr_data = '0; ctx_load = 1'b0; ctx_store = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 in reset", out_valid, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_data_packet();
    t_carry();
    t_cfg_packet();
    t_load();
    t_store_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule